// File: doc/BRIEF.md
# Out-of-Order Completion Reorder Buffer

This block keeps program order for a pipeline whose instructions finish out of order. Every instruction takes a slot at issue, in program order. The slot holds the destination register number and a flag that says whether the result is needed in the register file. The slot tag travels with the instruction. When an execution path finishes, it writes the result and a fault flag into the slot through one of several fill ports. Fill ports may write in the same cycle as long as they target different slots.

The oldest slot leaves the buffer only after it has been filled, and at most one slot leaves per cycle. A slot that leaves with its wanted flag set drives a register-file write. An unwanted slot leaves without one. A slot that leaves gives up its place, but its data stays readable for forwarding until the slot is handed out again. A lookup by register number returns the youngest filled result for that register.

When the oldest slot carries a fault, the block reports an exception instead of retiring it. It then discards that slot and every younger slot, which keeps exceptions precise. Slot count must be a power of two.

Top module: `rob_core`

## Requirements
- R1: `alloc_ready` is high while fewer than DEPTH (8) slots are occupied and no exception is being reported. An accepted allocation takes the slot given by `alloc_tag`, and successive tags step by one modulo DEPTH. An allocation request made while the buffer is full has no effect.
- R2: Both fill ports may write different slots in the same cycle. Two ports must never name the same slot in one cycle. A fill aimed at a slot that is not occupied has no effect, including on forwarding.
- R3: Slots retire strictly in allocation order, one per cycle, and only once the oldest slot is filled, whatever the order of fills. `retire_valid` is high in the cycle a slot retires.
- R4: When the retiring slot is marked wanted, `rf_we` is high in that cycle, with `rf_addr` equal to the slot's destination and `rf_data` equal to its value. When it is unwanted, it retires with `rf_we` low.
- R5: `fwd_hit` goes high for the youngest slot whose destination equals `fwd_reg` and whose value was filled without a fault, and `fwd_data` then carries that value. Slots that are allocated but not yet filled are skipped. With no match, `fwd_hit` is 0 and `fwd_data` is 0.
- R6: A retired slot's value stays visible to forwarding until the slot is allocated again.
- R7: When the oldest slot is filled with its fault flag set, `exc_valid` is high and `exc_tag` names that slot, with no retirement and no register write. On the next cycle every occupied slot is empty, `alloc_tag` equals the faulting tag, and the faulting and flushed slots no longer forward.
- R8: After reset the buffer is empty: `alloc_ready` is 1, `alloc_tag` is 0, `retire_valid` and `exc_valid` are 0, and every lookup misses.
- R9: While `exc_valid` is high, `alloc_ready` is low and an allocation request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Request to take a slot for a new instruction |
| alloc_dest | input | REG_W | Destination register of the new instruction |
| alloc_wanted | input | 1 | The result must be written to the register file |
| alloc_ready | output | 1 | An allocation is accepted this cycle |
| alloc_tag | output | IDX_W | Slot that the next allocation takes |
| fill_valid | input | NUM_FILL | Per-port result write strobe |
| fill_tag | input | NUM_FILL x IDX_W | Per-port target slot |
| fill_data | input | NUM_FILL x DATA_W | Per-port result value |
| fill_fault | input | NUM_FILL | Per-port fault flag |
| retire_valid | output | 1 | The oldest slot retires this cycle |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | REG_W | Register-file write address |
| rf_data | output | DATA_W | Register-file write data |
| exc_valid | output | 1 | The oldest slot faulted; flush follows |
| exc_tag | output | IDX_W | Slot of the faulting instruction |
| fwd_reg | input | REG_W | Register number to look up |
| fwd_hit | output | 1 | A forwardable value exists |
| fwd_data | output | DATA_W | The forwarded value |

## Verification
In-order retirement is tried with fills that arrive youngest-first, oldest-next and middle-last. This separates a buffer that waits at its head from one that drains whatever is filled. Two simultaneous fills to different slots, one of them unwanted, separate a correct write gate from one that writes every retired value. Repeated results for one register show youngest-first priority, that unfilled slots are skipped, that retired data is kept, and that a stray fill to a free slot does not disturb it. A full buffer with an extra request checks the wrap of tags and the full limit. A fault on the oldest of three slots, filled last, checks the flush, the tag rewind and the absence of register writes.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef struct packed {
        logic busy;
        logic filled;
        logic fault;
        logic wanted;
        logic fwd_ok;
    } slot_flags_t;

    typedef enum logic [1:0] {
        HEAD_WAIT   = 2'd0,
        HEAD_RETIRE = 2'd1,
        HEAD_FAULT  = 2'd2
    } head_act_e;

endpackage

// File: rtl/rob_fill_decode.sv
module rob_fill_decode #(
    parameter int DEPTH    = 8,
    parameter int NUM_FILL = 2,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic [NUM_FILL-1:0]             fill_valid,
    input  logic [NUM_FILL-1:0][IDX_W-1:0]  fill_tag,
    input  logic [NUM_FILL-1:0][DATA_W-1:0] fill_data,
    input  logic [NUM_FILL-1:0]             fill_fault,
    output logic [DEPTH-1:0]                wr_en,
    output logic [DEPTH-1:0][DATA_W-1:0]    wr_data,
    output logic [DEPTH-1:0]                wr_fault
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic              en_l;
        logic [DATA_W-1:0] data_l;
        logic              fault_l;

        always_comb begin
            en_l    = 1'b0;
            data_l  = '0;
            fault_l = 1'b0;
            for (int p = 0; p < NUM_FILL; p++) begin
                if (fill_valid[p] && (fill_tag[p] == IDX_W'(g))) begin
                    en_l    = 1'b1;
                    data_l  = fill_data[p];
                    fault_l = fill_fault[p];
                end
            end
        end

        assign wr_en[g]    = en_l;
        assign wr_data[g]  = data_l;
        assign wr_fault[g] = fault_l;
    end

endmodule

// File: rtl/rob_fwd_search.sv
module rob_fwd_search #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             slot_ok,
    input  logic [DEPTH-1:0][REG_W-1:0]  slot_dest,
    input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
    input  logic [IDX_W-1:0]             tail_idx,
    input  logic [REG_W-1:0]             look_reg,
    output logic                         hit,
    output logic [DATA_W-1:0]            hit_data
);

    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = slot_ok[g] && (slot_dest[g] == look_reg);
    end

    // Walk from the oldest position (tail) towards the youngest (tail-1);
    // later assignments override, so the youngest match wins.
    always_comb begin
        logic [IDX_W-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int k = DEPTH; k >= 1; k--) begin
            idx = tail_idx - IDX_W'(k);
            if (match[idx]) begin
                hit      = 1'b1;
                hit_data = slot_data[idx];
            end
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int REG_W    = 5,
    parameter int DATA_W   = 32,
    parameter int NUM_FILL = 2,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int PTR_W   = IDX_W + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            alloc_valid,
    input  logic [REG_W-1:0]                alloc_dest,
    input  logic                            alloc_wanted,
    output logic                            alloc_ready,
    output logic [IDX_W-1:0]                alloc_tag,
    input  logic [NUM_FILL-1:0]             fill_valid,
    input  logic [NUM_FILL-1:0][IDX_W-1:0]  fill_tag,
    input  logic [NUM_FILL-1:0][DATA_W-1:0] fill_data,
    input  logic [NUM_FILL-1:0]             fill_fault,
    output logic                            retire_valid,
    output logic                            rf_we,
    output logic [REG_W-1:0]                rf_addr,
    output logic [DATA_W-1:0]               rf_data,
    output logic                            exc_valid,
    output logic [IDX_W-1:0]                exc_tag,
    input  logic [REG_W-1:0]                fwd_reg,
    output logic                            fwd_hit,
    output logic [DATA_W-1:0]               fwd_data
);

    typedef struct packed {
        logic [PTR_W-1:0]                head;
        logic [PTR_W-1:0]                tail;
        slot_flags_t [DEPTH-1:0]         flg;
        logic [DEPTH-1:0][REG_W-1:0]     dest;
        logic [DEPTH-1:0][DATA_W-1:0]    data;
    } state_t;

    state_t s_d, s_q;

    logic [DEPTH-1:0]              wr_en;
    logic [DEPTH-1:0][DATA_W-1:0]  wr_data;
    logic [DEPTH-1:0]              wr_fault;
    logic [DEPTH-1:0]              slot_ok;

    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic             full;
    slot_flags_t      head_flg;
    head_act_e        head_act;
    logic             alloc_ok;

    rob_fill_decode #(
        .DEPTH   (DEPTH),
        .NUM_FILL(NUM_FILL),
        .DATA_W  (DATA_W)
    ) u_fill (
        .fill_valid(fill_valid),
        .fill_tag  (fill_tag),
        .fill_data (fill_data),
        .fill_fault(fill_fault),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_fault  (wr_fault)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_ok
        assign slot_ok[g] = s_q.flg[g].fwd_ok;
    end

    rob_fwd_search #(
        .DEPTH (DEPTH),
        .REG_W (REG_W),
        .DATA_W(DATA_W)
    ) u_fwd (
        .slot_ok  (slot_ok),
        .slot_dest(s_q.dest),
        .slot_data(s_q.data),
        .tail_idx (tail_idx),
        .look_reg (fwd_reg),
        .hit      (fwd_hit),
        .hit_data (fwd_data)
    );

    // Head status decode
    always_comb begin
        head_idx = s_q.head[IDX_W-1:0];
        tail_idx = s_q.tail[IDX_W-1:0];
        full     = (head_idx == tail_idx) && (s_q.head[IDX_W] != s_q.tail[IDX_W]);
        head_flg = s_q.flg[head_idx];
        head_act = HEAD_WAIT;
        if (head_flg.busy && head_flg.filled) begin
            head_act = head_flg.fault ? HEAD_FAULT : HEAD_RETIRE;
        end
        alloc_ok = alloc_valid && !full && (head_act != HEAD_FAULT);
    end

    // Next-state computation
    always_comb begin
        s_d = s_q;

        // Completion writes land only in occupied slots
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_en[i] && s_q.flg[i].busy) begin
                s_d.flg[i].filled = 1'b1;
                s_d.flg[i].fault  = wr_fault[i];
                s_d.flg[i].fwd_ok = !wr_fault[i];
                s_d.data[i]       = wr_data[i];
            end
        end

        // In-order retirement frees the slot; value stays for forwarding
        if (head_act == HEAD_RETIRE) begin
            s_d.flg[head_idx].busy = 1'b0;
            s_d.head               = s_q.head + PTR_W'(1);
        end

        // Allocation in program order
        if (alloc_ok) begin
            s_d.flg[tail_idx]        = '0;
            s_d.flg[tail_idx].busy   = 1'b1;
            s_d.flg[tail_idx].wanted = alloc_wanted;
            s_d.dest[tail_idx]       = alloc_dest;
            s_d.tail                 = s_q.tail + PTR_W'(1);
        end

        // Precise exception: drop the faulting slot and everything younger
        if (head_act == HEAD_FAULT) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (s_q.flg[i].busy) begin
                    s_d.flg[i] = '0;
                end
            end
            s_d.tail = s_q.head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign alloc_ready  = !full && (head_act != HEAD_FAULT);
    assign alloc_tag    = tail_idx;
    assign retire_valid = (head_act == HEAD_RETIRE);
    assign rf_we        = (head_act == HEAD_RETIRE) && head_flg.wanted;
    assign rf_addr      = s_q.dest[head_idx];
    assign rf_data      = s_q.data[head_idx];
    assign exc_valid    = (head_act == HEAD_FAULT);
    assign exc_tag      = head_idx;

endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
    parameter int DEPTH    = 8,
    parameter int NUM_FILL = 2,
    localparam int IDX_W   = $clog2(DEPTH),
    localparam int OCC_W   = $clog2(DEPTH + 1)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           alloc_valid,
    input logic                           alloc_ready,
    input logic [IDX_W-1:0]               alloc_tag,
    input logic [NUM_FILL-1:0]            fill_valid,
    input logic [NUM_FILL-1:0][IDX_W-1:0] fill_tag,
    input logic                           retire_valid,
    input logic                           rf_we,
    input logic                           exc_valid,
    input logic [IDX_W-1:0]               exc_tag
);

    logic [OCC_W-1:0] occ_q;
    logic             collide;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (exc_valid) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OCC_W'(alloc_valid && alloc_ready) - OCC_W'(retire_valid);
        end
    end

    always_comb begin
        collide = 1'b0;
        for (int a = 0; a < NUM_FILL; a++) begin
            for (int b = a + 1; b < NUM_FILL; b++) begin
                if (fill_valid[a] && fill_valid[b] && (fill_tag[a] == fill_tag[b])) begin
                    collide = 1'b1;
                end
            end
        end
    end

    assert_fill_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !collide);

    assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(DEPTH));

    assert_full_blocks_alloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OCC_W'(DEPTH)) |-> !alloc_ready);

    assert_retire_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retire_valid |-> (occ_q != '0));

    assert_write_needs_retire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> retire_valid);

    assert_exc_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (!retire_valid && !rf_we));

    assert_tail_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |=> (alloc_tag == $past(exc_tag)));

    assert_exc_blocks_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !alloc_ready);

endmodule

bind rob_core rob_core_chk #(
    .DEPTH   (DEPTH),
    .NUM_FILL(NUM_FILL)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .alloc_tag   (alloc_tag),
    .fill_valid  (fill_valid),
    .fill_tag    (fill_tag),
    .retire_valid(retire_valid),
    .rf_we       (rf_we),
    .exc_valid   (exc_valid),
    .exc_tag     (exc_tag)
);

// File: tb/sim_rob_core.sv
module sim_rob_core;

    localparam int DEPTH  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NF     = 2;
    localparam int IW     = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      alloc_valid = 1'b0;
    logic [REG_W-1:0]          alloc_dest = '0;
    logic                      alloc_wanted = 1'b0;
    logic                      alloc_ready;
    logic [IW-1:0]             alloc_tag;
    logic [NF-1:0]             fill_valid = '0;
    logic [NF-1:0][IW-1:0]     fill_tag = '0;
    logic [NF-1:0][DATA_W-1:0] fill_data = '0;
    logic [NF-1:0]             fill_fault = '0;
    logic                      retire_valid;
    logic                      rf_we;
    logic [REG_W-1:0]          rf_addr;
    logic [DATA_W-1:0]         rf_data;
    logic                      exc_valid;
    logic [IW-1:0]             exc_tag;
    logic [REG_W-1:0]          fwd_reg = '0;
    logic                      fwd_hit;
    logic [DATA_W-1:0]         fwd_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int          n_ret = 0;
    logic        log_we   [16];
    logic [4:0]  log_addr [16];
    logic [31:0] log_data [16];

    always #10 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W), .NUM_FILL(NF)) u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_dest(alloc_dest), .alloc_wanted(alloc_wanted),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
        .fill_valid(fill_valid), .fill_tag(fill_tag), .fill_data(fill_data), .fill_fault(fill_fault),
        .retire_valid(retire_valid), .rf_we(rf_we), .rf_addr(rf_addr), .rf_data(rf_data),
        .exc_valid(exc_valid), .exc_tag(exc_tag),
        .fwd_reg(fwd_reg), .fwd_hit(fwd_hit), .fwd_data(fwd_data)
    );

    // Retirement monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && retire_valid && n_ret < 16) begin
            log_we[n_ret]   = rf_we;
            log_addr[n_ret] = rf_addr;
            log_data[n_ret] = rf_data;
            n_ret = n_ret + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic alloc_one(input logic [4:0] d, input bit w, output logic [IW-1:0] t);
        alloc_valid  = 1'b1;
        alloc_dest   = d;
        alloc_wanted = w;
        #1;
        t = alloc_tag;
        check(alloc_ready == 1'b1, "R1 alloc accepted", 32'(alloc_ready), 1);
        @(posedge clk);
        #2;
        alloc_valid = 1'b0;
    endtask

    task automatic fill_one(input int p, input logic [IW-1:0] t, input logic [31:0] d, input bit f);
        fill_valid[p] = 1'b1;
        fill_tag[p]   = t;
        fill_data[p]  = d;
        fill_fault[p] = f;
        @(posedge clk);
        #2;
        fill_valid = '0;
        fill_fault = '0;
    endtask

    task automatic fill_two(input logic [IW-1:0] ta, input logic [31:0] da,
                            input logic [IW-1:0] tb, input logic [31:0] db);
        fill_valid = 2'b11;
        fill_tag[0] = ta; fill_data[0] = da;
        fill_tag[1] = tb; fill_data[1] = db;
        fill_fault = '0;
        @(posedge clk);
        #2;
        fill_valid = '0;
    endtask

    task automatic lookup(input logic [4:0] r, output logic h, output logic [31:0] d);
        fwd_reg = r;
        #1;
        h = fwd_hit;
        d = fwd_data;
    endtask

    task automatic t_reset();
        check(alloc_ready == 1'b1, "R8 ready after reset", 32'(alloc_ready), 1);
        check(alloc_tag == 3'd0, "R8 tag after reset", 32'(alloc_tag), 0);
        check(!retire_valid && !exc_valid, "R8 idle after reset", 32'({retire_valid, exc_valid}), 0);
        check(!fwd_hit && fwd_data == 0, "R8 lookup misses", 32'(fwd_hit), 0);
    endtask

    task automatic t_in_order();
        logic [IW-1:0] t0, t1, t2;
        n_ret = 0;
        alloc_one(5'd1, 1'b1, t0);
        alloc_one(5'd2, 1'b1, t1);
        alloc_one(5'd3, 1'b1, t2);
        check(t1 == t0 + 3'd1 && t2 == t0 + 3'd2, "R1 tags consecutive", 32'(t2), 32'(t0 + 3'd2));
        fill_one(0, t2, 32'h30, 1'b0);
        idle(3);
        check(n_ret == 0, "R3 youngest fill alone does not retire", n_ret, 0);
        fill_one(1, t0, 32'h10, 1'b0);
        idle(3);
        check(n_ret == 1, "R3 oldest retires once filled", n_ret, 1);
        check(log_addr[0] == 5'd1 && log_data[0] == 32'h10 && log_we[0], "R4 first write", log_data[0], 32'h10);
        fill_one(1, t1, 32'h20, 1'b0);
        idle(3);
        check(n_ret == 3, "R3 remaining drain", n_ret, 3);
        check(log_addr[1] == 5'd2 && log_addr[2] == 5'd3, "R3 program order", 32'(log_addr[2]), 3);
        check(log_data[1] == 32'h20 && log_data[2] == 32'h30, "R4 written values", log_data[2], 32'h30);
    endtask

    task automatic t_dual_unwanted();
        logic [IW-1:0] ta, tb;
        n_ret = 0;
        alloc_one(5'd5, 1'b1, ta);
        alloc_one(5'd6, 1'b0, tb);
        fill_two(ta, 32'h55, tb, 32'h66);
        idle(3);
        check(n_ret == 2, "R2 simultaneous fills both land", n_ret, 2);
        check(log_we[0] && log_addr[0] == 5'd5 && log_data[0] == 32'h55, "R4 wanted write", log_data[0], 32'h55);
        check(log_we[1] == 1'b0, "R4 unwanted retires silently", 32'(log_we[1]), 0);
    endtask

    task automatic t_forward();
        logic [IW-1:0] ta, tb;
        logic h;
        logic [31:0] d;
        alloc_one(5'd7, 1'b1, ta);
        fill_one(0, ta, 32'h111, 1'b0);
        idle(2);
        lookup(5'd7, h, d);
        check(h && d == 32'h111, "R6 retired value forwarded", d, 32'h111);
        alloc_one(5'd7, 1'b1, tb);
        lookup(5'd7, h, d);
        check(h && d == 32'h111, "R5 unfilled match skipped", d, 32'h111);
        fill_one(0, tb, 32'h222, 1'b0);
        lookup(5'd7, h, d);
        check(h && d == 32'h222, "R5 youngest match wins", d, 32'h222);
        idle(2);
        fill_one(1, tb, 32'h999, 1'b0);
        lookup(5'd7, h, d);
        check(h && d == 32'h222, "R2 fill to free slot ignored", d, 32'h222);
        lookup(5'd9, h, d);
        check(!h && d == 0, "R5 miss gives zero", d, 0);
    endtask

    task automatic t_full();
        logic [IW-1:0] t [8];
        logic h;
        logic [31:0] d;
        bit ok;
        n_ret = 0;
        for (int k = 0; k < 8; k++) begin
            alloc_one(5'(16 + k), 1'b1, t[k]);
        end
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (t[k] != t[0] + 3'(k)) ok = 1'b0;
        end
        check(ok, "R1 tags wrap modulo depth", 32'(t[7]), 32'(t[0] + 3'd7));
        alloc_valid  = 1'b1;
        alloc_dest   = 5'd30;
        alloc_wanted = 1'b1;
        #1;
        check(alloc_ready == 1'b0, "R1 full refuses allocation", 32'(alloc_ready), 0);
        @(posedge clk);
        #2;
        alloc_valid = 1'b0;
        for (int k = 0; k < 8; k += 2) begin
            fill_two(t[k], 32'h500 + 32'(k), t[k+1], 32'h500 + 32'(k + 1));
        end
        idle(10);
        check(n_ret == 8, "R1 request while full had no effect", n_ret, 8);
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            if (log_addr[k] != 5'(16 + k) || log_data[k] != 32'h500 + 32'(k)) ok = 1'b0;
        end
        check(ok, "R3 full drain in order", log_data[7], 32'h507);
        lookup(5'd7, h, d);
        check(!h, "R6 reallocated slot no longer forwards", 32'(h), 0);
    endtask

    task automatic t_exception();
        logic [IW-1:0] t0, t1, t2, tn;
        logic h;
        logic [31:0] d;
        n_ret = 0;
        alloc_one(5'd10, 1'b1, t0);
        alloc_one(5'd11, 1'b1, t1);
        alloc_one(5'd12, 1'b1, t2);
        fill_two(t1, 32'hB1, t2, 32'hB2);
        fill_one(0, t0, 32'hDEAD, 1'b1);
        alloc_valid  = 1'b1;
        alloc_dest   = 5'd30;
        alloc_wanted = 1'b1;
        #1;
        check(exc_valid && exc_tag == t0, "R7 exception on oldest", 32'(exc_tag), 32'(t0));
        check(!retire_valid && !rf_we, "R7 no retire on fault", 32'({retire_valid, rf_we}), 0);
        check(alloc_ready == 1'b0, "R9 allocation blocked during exception", 32'(alloc_ready), 0);
        @(posedge clk);
        #2;
        alloc_valid = 1'b0;
        #1;
        check(!exc_valid && alloc_ready && alloc_tag == t0, "R7 tail rewound to fault", 32'(alloc_tag), 32'(t0));
        lookup(5'd11, h, d);
        check(!h, "R7 flushed slot not forwarded", 32'(h), 0);
        lookup(5'd10, h, d);
        check(!h, "R7 faulted slot not forwarded", 32'(h), 0);
        idle(3);
        check(n_ret == 0, "R7 nothing written after flush", n_ret, 0);
        alloc_one(5'd4, 1'b1, tn);
        check(tn == t0, "R7 next allocation reuses faulting slot", 32'(tn), 32'(t0));
        fill_one(1, tn, 32'h444, 1'b0);
        idle(3);
        check(n_ret == 1 && log_addr[0] == 5'd4 && log_data[0] == 32'h444, "R3 resumes after flush", log_data[0], 32'h444);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        #1;
        t_reset();
        idle(1);
        t_in_order();
        t_dual_unwanted();
        t_forward();
        t_full();
        t_exception();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule